// File: doc/BRIEF.md
# Serial In-System Code Array Programmer

This block is a serial slave port through which an external programmer erases, loads, reads back and locks a byte-wide on-chip code array of 4096 locations. It is active while the level input `prog_en` is high. The programmer drives `sck` and `mosi`, and the block answers on `miso`. Both lines are sampled by the fast system clock through two-flop synchronisers. Edges of `sck` are detected in the system clock domain, so `sck` must run slower than one sixteenth of `clk`.

Every instruction is framed in bytes, most significant bit first. Single-location instructions are four bytes long. The page instructions are a command byte and a page byte followed by a stream of 256 data bytes, which always starts at offset 0 of the selected page. The array is behavioural. Programming can only clear bits. Erase and write are self-timed, and their durations are set by the cycle-count parameters `ERASE_CYCLES` and `WRITE_CYCLES`. Three lock bits raise the protection level in a fixed order.

The command decoder is a five-state machine. `C_OPCODE` takes the command byte, and `C_ARG1` takes the address-high or page byte. It then moves to `C_PAGE` for an enabled page command and to `C_ARG2` otherwise. `C_ARG2` takes the address-low byte and prepares the reply. `C_ARG3` carries out the instruction and returns to `C_OPCODE`. `C_PAGE` counts 256 data bytes and then returns to `C_OPCODE`. Dropping `prog_en` forces the decoder back to `C_OPCODE`. The array engine has three states. `E_READY` moves to `E_ERASE` on an erase request and to `E_WRITE` on a write request. A write request in `E_WRITE` restarts its timer. Both busy states return to `E_READY` when their count expires. The engine enters `E_ERASE` with fill value 00h when the system is reset.

Top module: `isp_serial_port`

## Requirements
- R1: Each bit on `mosi` is captured on a rising `sck` edge. `miso` changes only after a falling `sck` edge and presents, MSB first, the reply byte for the current byte slot. The byte after the command byte and the page byte of a page command carry the address high bits in bits [3:0].
- R2: Until the enable instruction (AC 53 xx xx) has completed, every other instruction has no effect. The enable instruction returns 69h in its fourth byte. Dropping `prog_en` cancels the enabled state.
- R3: After `prog_en` rises, `sck` edges are ignored until `sck` has been seen low for 64 consecutive system clocks.
- R4: Byte read (20 aH aL xx) returns the content of address {aH[3:0], aL} in the fourth byte.
- R5: Byte write (40 aH aL dd) stores the old content AND dd, so without a prior erase a location cannot take the value written.
- R6: A byte write keeps the array busy for `WRITE_CYCLES` clocks. During that time a read of the last written address returns the byte with bit 7 inverted, and a read of any other address returns its true value.
- R7: Chip erase (AC 80 xx xx) sets every location to FFh over `ERASE_CYCLES` clocks, clears all lock bits and makes every read return 00h while it runs. Writes issued during an erase are dropped.
- R8: Page read (30 pg) is followed by 256 bytes carrying the locations {pg[3:0], 00h} through {pg[3:0], FFh} in order.
- R9: Page write (50 pg) is followed by 256 data bytes that are programmed, with the same bit-clearing rule, into offsets 0 to 255 of page pg[3:0].
- R10: Lock write is AC (E0h|s) xx xx. s=1 sets lock 1. s=2 sets lock 2 only if lock 1 is set. s=3 sets lock 3 only if lock 2 is set. Any other request leaves the lock bits unchanged.
- R11: Lock read (24 xx xx xx) returns the lock bits in the fourth byte: lock 1 in bit 2, lock 2 in bit 3 and lock 3 in bit 4, each set lock reading as 1.
- R12: With lock 1 set, byte and page writes have no effect.
- R13: With lock 2 set, byte and page reads return 00h.
- R14: After system reset `miso` is 0, the lock bits are clear and, once the reset fill of `ERASE_CYCLES` clocks has run, every location reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| prog_en | input | 1 | Programming session level; high enables the serial port |
| sck | input | 1 | Serial shift clock from the programmer |
| mosi | input | 1 | Serial instruction and data input |
| miso | output | 1 | Serial reply output |

## Verification
The state that is hardest to reach from the pins is the narrow window in which a self-timed operation is still running and a reply is being prepared. In that window the complemented-MSB polling value or the forced 00h erase value must appear instead of array content. The stimulus starts a read instruction directly after the write or erase instruction that began the operation. It reads the last written address and then an unrelated one, and the default write time is longer than the three bytes a read needs before its reply is prepared. Random address and data pairs, checked against a bench model of the bit-clearing array, are mixed with directed cases for the lock-order escalation, the stray `sck` pulse before arming, and instructions sent before enable.

// File: rtl/isp_pkg.sv
package isp_pkg;

    // Command byte values and sub-codes (second byte of prefixed commands)
    localparam logic [7:0] OP_PREFIX   = 8'hAC;
    localparam logic [7:0] SUB_ENABLE  = 8'h53;
    localparam logic [7:0] SUB_ERASE   = 8'h80;
    localparam logic [5:0] SUB_LOCK_HI = 6'b111000;
    localparam logic [7:0] OP_RD_BYTE  = 8'h20;
    localparam logic [7:0] OP_WR_BYTE  = 8'h40;
    localparam logic [7:0] OP_RD_PAGE  = 8'h30;
    localparam logic [7:0] OP_WR_PAGE  = 8'h50;
    localparam logic [7:0] OP_RD_LOCK  = 8'h24;
    localparam logic [7:0] ENABLE_ECHO = 8'h69;

    typedef enum logic [2:0] {
        C_OPCODE,
        C_ARG1,
        C_ARG2,
        C_ARG3,
        C_PAGE
    } cmd_state_t;

    typedef enum logic [1:0] {
        E_READY,
        E_ERASE,
        E_WRITE
    } eng_state_t;

endpackage

// File: rtl/isp_sck_front.sv
module isp_sck_front #(
    parameter int GUARD_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic sck,
    input  logic mosi,
    output logic en_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_bit
);
    localparam int GW = $clog2(GUARD_CLKS + 1);

    logic          pe_m, pe_s;
    logic          sck_m, sck_s, sck_d;
    logic          mosi_m, mosi_s;
    logic [GW-1:0] guard_cnt;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_m      <= 1'b0;
            pe_s      <= 1'b0;
            sck_m     <= 1'b0;
            sck_s     <= 1'b0;
            sck_d     <= 1'b0;
            mosi_m    <= 1'b0;
            mosi_s    <= 1'b0;
            guard_cnt <= '0;
            armed     <= 1'b0;
        end else begin
            pe_m   <= prog_en;
            pe_s   <= pe_m;
            sck_m  <= sck;
            sck_s  <= sck_m;
            sck_d  <= sck_s;
            mosi_m <= mosi;
            mosi_s <= mosi_m;
            if (!pe_s) begin
                armed     <= 1'b0;
                guard_cnt <= '0;
            end else if (!armed) begin
                if (sck_s) begin
                    guard_cnt <= '0;
                end else if (guard_cnt == GW'(GUARD_CLKS - 1)) begin
                    armed <= 1'b1;
                end else begin
                    guard_cnt <= guard_cnt + 1'b1;
                end
            end
        end
    end

    assign en_s     = pe_s;
    assign mosi_bit = mosi_s;
    assign sck_rise = armed & sck_s & ~sck_d;
    assign sck_fall = armed & ~sck_s & sck_d;

    // R3: no shift edge is passed while the session input is low
    p_no_edge_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_s |-> !(sck_rise || sck_fall));

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_bit,
    input  logic [7:0] tx_byte,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr;
    logic [7:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else if (clear) begin
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[6:0], mosi_bit};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_byte    <= {rx_sr[6:0], mosi_bit};
                    byte_valid <= 1'b1;
                end
            end else if (sck_fall) begin
                if (bit_cnt == 3'd0) begin
                    tx_sr <= tx_byte;
                end else begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx_sr[7];

    // R1: a completed byte is always the result of a rising shift edge
    p_byte_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(sck_rise));

endmodule

// File: rtl/isp_code_array.sv
module isp_code_array
    import isp_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int ERASE_CYCLES = 4200,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              erasing
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAXC  = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int CW    = $clog2(MAXC + 1);

    logic [7:0]        mem [DEPTH];
    eng_state_t        st_q;
    logic [CW-1:0]     tcnt;
    logic [7:0]        fill_q;
    logic [ADDR_W-1:0] last_q;
    logic              sweep_en;
    logic [ADDR_W-1:0] sweep_addr;

    assign sweep_en   = (st_q == E_ERASE) && (tcnt < CW'(DEPTH));
    assign sweep_addr = tcnt[ADDR_W-1:0];

    // State register and timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= E_ERASE;
            tcnt   <= '0;
            fill_q <= 8'h00;
            last_q <= '0;
        end else begin
            unique case (st_q)
                E_READY: begin
                    if (erase_req) begin
                        st_q   <= E_ERASE;
                        tcnt   <= '0;
                        fill_q <= 8'hFF;
                    end else if (wr_req) begin
                        st_q   <= E_WRITE;
                        tcnt   <= '0;
                        last_q <= wr_addr;
                    end
                end
                E_ERASE: begin
                    if (tcnt == CW'(ERASE_CYCLES - 1)) begin
                        st_q <= E_READY;
                        tcnt <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                E_WRITE: begin
                    if (wr_req) begin
                        tcnt   <= '0;
                        last_q <= wr_addr;
                    end else if (tcnt == CW'(WRITE_CYCLES - 1)) begin
                        st_q <= E_READY;
                        tcnt <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st_q <= E_READY;
            endcase
        end
    end

    // Array write port: erase sweep has priority, programming clears bits only
    always_ff @(posedge clk) begin
        if (sweep_en) begin
            mem[sweep_addr] <= fill_q;
        end else if (wr_req && (st_q != E_ERASE)) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // Read view with erase masking and write polling
    always_comb begin
        unique case (st_q)
            E_ERASE: rd_data = 8'h00;
            E_WRITE: rd_data = (rd_addr == last_q) ? (mem[rd_addr] ^ 8'h80) : mem[rd_addr];
            default: rd_data = mem[rd_addr];
        endcase
    end

    assign busy    = (st_q != E_READY);
    assign erasing = (st_q == E_ERASE);

    // R7: each swept location holds the fill value one cycle later
    p_sweep_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |=> mem[$past(sweep_addr)] == $past(fill_q));

    // R6: a write request outside an erase always leaves the engine writing
    p_write_goes_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && st_q != E_ERASE && !erase_req) |=> st_q == E_WRITE);

endmodule

// File: rtl/isp_cmd_ctrl.sv
module isp_cmd_ctrl
    import isp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rd_data,
    input  logic              busy,
    input  logic              erasing,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              erase_req
);
    localparam int PB = ADDR_W - 8;

    cmd_state_t st_q, st_d;
    logic [7:0] op_q, op_d;
    logic [7:0] a1_q, a1_d;
    logic [7:0] a2_q, a2_d;
    logic [7:0] pg_q, pg_d;
    logic       en_q, en_d;
    logic [2:0] lk_q, lk_d;
    logic [7:0] tx_q, tx_d;
    logic [7:0] rd_view;
    logic       page_op;

    assign page_op = en_q && ((op_q == OP_RD_PAGE) || (op_q == OP_WR_PAGE));
    assign rd_view = lk_q[1] ? 8'h00 : rd_data;

    // Read address presented to the array for the reply being prepared
    always_comb begin
        unique case (st_q)
            C_ARG1:  rd_addr = {rx_byte[PB-1:0], 8'h00};
            C_ARG2:  rd_addr = {a1_q[PB-1:0], rx_byte};
            C_PAGE:  rd_addr = {a1_q[PB-1:0], pg_q + 8'd1};
            default: rd_addr = '0;
        endcase
    end

    // Next-state and request logic
    always_comb begin
        st_d      = st_q;
        op_d      = op_q;
        a1_d      = a1_q;
        a2_d      = a2_q;
        pg_d      = pg_q;
        en_d      = en_q;
        lk_d      = lk_q;
        tx_d      = tx_q;
        wr_req    = 1'b0;
        erase_req = 1'b0;
        wr_addr   = '0;
        wr_data   = rx_byte;
        if (!en_s) begin
            st_d = C_OPCODE;
            en_d = 1'b0;
            tx_d = 8'h00;
            pg_d = 8'h00;
        end else if (byte_valid) begin
            unique case (st_q)
                C_OPCODE: begin
                    op_d = rx_byte;
                    tx_d = 8'h00;
                    st_d = C_ARG1;
                end
                C_ARG1: begin
                    a1_d = rx_byte;
                    pg_d = 8'h00;
                    if (page_op) begin
                        tx_d = (op_q == OP_RD_PAGE) ? rd_view : 8'h00;
                        st_d = C_PAGE;
                    end else begin
                        tx_d = 8'h00;
                        st_d = C_ARG2;
                    end
                end
                C_ARG2: begin
                    a2_d = rx_byte;
                    tx_d = 8'h00;
                    if (op_q == OP_PREFIX && a1_q == SUB_ENABLE) begin
                        tx_d = ENABLE_ECHO;
                    end else if (en_q && op_q == OP_RD_BYTE) begin
                        tx_d = rd_view;
                    end else if (en_q && op_q == OP_RD_LOCK) begin
                        tx_d = {3'b000, lk_q, 2'b00};
                    end
                    st_d = C_ARG3;
                end
                C_ARG3: begin
                    tx_d = 8'h00;
                    st_d = C_OPCODE;
                    if (op_q == OP_PREFIX && a1_q == SUB_ENABLE) begin
                        en_d = 1'b1;
                    end else if (en_q && op_q == OP_PREFIX && a1_q == SUB_ERASE) begin
                        if (!busy) begin
                            erase_req = 1'b1;
                            lk_d      = 3'b000;
                        end
                    end else if (en_q && op_q == OP_PREFIX && a1_q[7:2] == SUB_LOCK_HI) begin
                        if (!erasing) begin
                            case (a1_q[1:0])
                                2'd1:    lk_d[0] = 1'b1;
                                2'd2:    lk_d[1] = lk_q[0];
                                2'd3:    lk_d[2] = lk_q[1];
                                default: lk_d    = lk_q;
                            endcase
                        end
                    end else if (en_q && op_q == OP_WR_BYTE) begin
                        if (!lk_q[0] && !erasing) begin
                            wr_req  = 1'b1;
                            wr_addr = {a1_q[PB-1:0], a2_q};
                        end
                    end
                end
                C_PAGE: begin
                    tx_d = 8'h00;
                    if (op_q == OP_RD_PAGE && pg_q != 8'hFF) begin
                        tx_d = rd_view;
                    end
                    if (op_q == OP_WR_PAGE && !lk_q[0] && !erasing) begin
                        wr_req  = 1'b1;
                        wr_addr = {a1_q[PB-1:0], pg_q};
                    end
                    pg_d = pg_q + 8'd1;
                    if (pg_q == 8'hFF) begin
                        st_d = C_OPCODE;
                    end
                end
                default: st_d = C_OPCODE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= C_OPCODE;
            op_q <= '0;
            a1_q <= '0;
            a2_q <= '0;
            pg_q <= '0;
            en_q <= 1'b0;
            lk_q <= '0;
            tx_q <= '0;
        end else begin
            st_q <= st_d;
            op_q <= op_d;
            a1_q <= a1_d;
            a2_q <= a2_d;
            pg_q <= pg_d;
            en_q <= en_d;
            lk_q <= lk_d;
            tx_q <= tx_d;
        end
    end

    assign tx_byte = tx_q;

    // R2: array operations are only requested in an enabled session
    p_req_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || erase_req) |-> en_q);

    // R10: lock levels are only ever reached in order
    p_lock3_needs_lock2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q[2] |-> lk_q[1]);
    p_lock2_needs_lock1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q[1] |-> lk_q[0]);

    // R12: no write is requested once lock 1 is set
    p_write_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !lk_q[0]);

    // R7: an accepted erase leaves all lock bits clear
    p_erase_clears_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> (lk_q == 3'b000));

endmodule

// File: rtl/isp_serial_port.sv
module isp_serial_port #(
    parameter int ADDR_W       = 12,
    parameter int ERASE_CYCLES = 4200,
    parameter int WRITE_CYCLES = 1000,
    parameter int GUARD_CLKS   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    logic              en_s;
    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_bit;
    logic              byte_valid;
    logic [7:0]        rx_byte;
    logic [7:0]        tx_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              busy;
    logic              erasing;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              erase_req;

    isp_sck_front #(.GUARD_CLKS(GUARD_CLKS)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .sck      (sck),
        .mosi     (mosi),
        .en_s     (en_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_bit (mosi_bit)
    );

    isp_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (~en_s),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .mosi_bit   (mosi_bit),
        .tx_byte    (tx_byte),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .miso       (miso)
    );

    isp_cmd_ctrl #(.ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_s       (en_s),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .rd_data    (rd_data),
        .busy       (busy),
        .erasing    (erasing),
        .tx_byte    (tx_byte),
        .rd_addr    (rd_addr),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .erase_req  (erase_req)
    );

    isp_code_array #(
        .ADDR_W       (ADDR_W),
        .ERASE_CYCLES (ERASE_CYCLES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_req (erase_req),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .erasing   (erasing)
    );

endmodule

// File: tb/isp_serial_port_test.sv
`timescale 1ns/1ps
module isp_serial_port_test;
    localparam int ERASE_CYC = 4200;
    localparam int WRITE_CYC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] model [4096];
    logic [7:0] pbuf [256];

    always #2.5 clk = ~clk;

    isp_serial_port uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            tick(5);
            r[i] = miso;
            sck = 1'b1;
            tick(10);
            sck = 1'b0;
            tick(5);
        end
    endtask

    task automatic instr(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3,
                         output logic [7:0] r);
        logic [7:0] d;
        xfer(b0, d);
        xfer(b1, d);
        xfer(b2, d);
        xfer(b3, r);
    endtask

    function automatic logic [7:0] rd_cmd_hi(input int a);
        return 8'((a >> 8) & 15);
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        model[a] = model[a] & d;
    endtask

    task automatic model_erase();
        for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        int unsigned seed;
        int a;
        logic [7:0] d;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        for (int i = 0; i < 4096; i++) model[i] = 8'h00;

        // R14: reset state
        tick(3);
        chk("R14 miso in reset", {7'b0, miso}, 8'h00);
        rst_n = 1'b1;
        tick(ERASE_CYC + 100);
        chk("R14 miso after reset", {7'b0, miso}, 8'h00);

        // R3: stray shift pulse right after session start must be ignored
        prog_en = 1'b1;
        tick(8);
        sck = 1'b1;
        tick(6);
        sck = 1'b0;
        tick(100);

        // R2: instructions before enable have no effect
        instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
        instr(8'hAC, 8'hE1, 8'h00, 8'h00, r);
        instr(8'h20, 8'h00, 8'h05, 8'h00, r);
        chk("R2 read before enable", r, 8'h00);
        tick(ERASE_CYC + 100);

        // R2/R3/R1: enable echo, bit alignment proves the stray edge was dropped
        instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R2 R3 enable echo", r, 8'h69);
        instr(8'h20, 8'h00, 8'h05, 8'h00, r);
        chk("R2 R14 erase before enable ignored", r, 8'h00);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R2 R11 lock write before enable ignored", r, 8'h00);

        // R5: write without erase cannot set bits
        instr(8'h40, 8'h0A, 8'h33, 8'h5A, r);
        tick(WRITE_CYC + 100);
        instr(8'h20, 8'h0A, 8'h33, 8'h00, r);
        chk("R5 write without erase flagged", r, 8'h00);

        // R7: erase, read during erase is 00, then FF
        instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        chk("R7 read during erase", r, 8'h00);
        tick(ERASE_CYC);
        model_erase();
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        chk("R7 erased location", r, 8'hFF);
        instr(8'h20, 8'h0F, 8'hFF, 8'h00, r);
        chk("R7 R4 erased top location", r, 8'hFF);

        // R6: polling shows complemented MSB, other addresses true
        instr(8'h40, 8'h02, 8'hA5, 8'h3C, r);
        model_write(12'h2A5, 8'h3C);
        instr(8'h20, 8'h02, 8'hA5, 8'h00, r);
        chk("R6 polling complement", r, 8'hBC);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        chk("R6 other address during write", r, 8'hFF);
        tick(WRITE_CYC + 100);
        instr(8'h20, 8'h02, 8'hA5, 8'h00, r);
        chk("R6 R4 true value after write", r, 8'h3C);

        // R4/R5: random writes against the bit-clearing model
        for (int k = 0; k < 8; k++) begin
            a = int'($urandom % 4096);
            d = 8'($urandom);
            instr(8'h40, rd_cmd_hi(a), 8'(a & 255), d, r);
            model_write(a, d);
            tick(WRITE_CYC + 100);
            instr(8'h20, rd_cmd_hi(a), 8'(a & 255), 8'h00, r);
            chk("R4 R5 random write readback", r, model[a]);
        end

        // R9: page write of page 7
        for (int i = 0; i < 256; i++) pbuf[i] = 8'($urandom);
        xfer(8'h50, r);
        xfer(8'h07, r);
        for (int i = 0; i < 256; i++) begin
            xfer(pbuf[i], r);
            model_write(12'h700 + i, pbuf[i]);
        end
        tick(WRITE_CYC + 100);

        // R8: page read of page 7
        xfer(8'h30, r);
        xfer(8'h07, r);
        for (int i = 0; i < 256; i++) begin
            xfer(8'h00, r);
            chk("R8 R9 page byte", r, model[12'h700 + i]);
        end
        instr(8'h20, 8'h07, 8'hFF, 8'h00, r);
        chk("R9 R4 page last byte by byte read", r, model[12'h7FF]);

        // R10/R11: lock order escalation
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R11 locks clear", r, 8'h00);
        instr(8'hAC, 8'hE2, 8'h00, 8'h00, r);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R10 lock2 out of order ignored", r, 8'h00);
        instr(8'hAC, 8'hE1, 8'h00, 8'h00, r);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R10 R11 lock1 set", r, 8'h04);

        // R12: lock mode 2 blocks writes
        instr(8'h40, 8'h01, 8'h00, 8'h11, r);
        tick(WRITE_CYC + 100);
        instr(8'h20, 8'h01, 8'h00, 8'h00, r);
        chk("R12 write blocked by lock1", r, model[12'h100]);

        // R13: lock 2 disables read verify
        instr(8'hAC, 8'hE2, 8'h00, 8'h00, r);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R10 R11 lock2 set", r, 8'h0C);
        instr(8'h20, 8'h02, 8'hA5, 8'h00, r);
        chk("R13 read blocked by lock2", r, 8'h00);
        instr(8'hAC, 8'hE3, 8'h00, 8'h00, r);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R10 R11 lock3 set", r, 8'h1C);

        // R7: erase clears the locks
        instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
        tick(ERASE_CYC + 100);
        model_erase();
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        chk("R7 erase clears locks", r, 8'h00);
        instr(8'h20, 8'h02, 8'hA5, 8'h00, r);
        chk("R7 R13 read after unlock", r, 8'hFF);

        // R2: dropping the session cancels enable
        prog_en = 1'b0;
        tick(20);
        prog_en = 1'b1;
        tick(100);
        instr(8'h20, 8'h02, 8'hA5, 8'h00, r);
        chk("R2 enable cancelled by session drop", r, 8'h00);
        instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R2 re-enable echo", r, 8'h69);
        instr(8'h20, 8'h02, 8'hA5, 8'h00, r);
        chk("R2 R4 read after re-enable", r, 8'hFF);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule